// File: doc/BRIEF.md
# Burst Address Sequencer for a Pipelined System Bus

This block is the address side of a bus master on a pipelined system bus. A local client issues one start command carrying a start address, a transfer size, a burst code and a direction. The sequencer then drives the address, the transfer type and the control outputs for every beat of that burst. It follows the bus ready signal, which stalls the address phase, and a local ready signal. When the local side is not ready between beats, the sequencer drives a BUSY transfer type.

The sequencer supports single transfers, an open-ended incrementing burst, and fixed incrementing and wrapping bursts of 4, 8 or 16 beats. For a wrapping burst, the wrap window is computed from both the size and the beat count. For any incrementing burst, the sequencer detects when the next beat would enter a new 1 KB region. It then starts that beat afresh as NONSEQ, so that no burst runs across the boundary. After the last beat is accepted, the transfer type returns to IDLE and a one-cycle done pulse is raised.

The control is a three-state machine:
- IDLE: nothing is presented.
- XFER: a NONSEQ or SEQ beat is on the bus.
- PAUSE: BUSY is presented, with the next beat's address already shown.

The transitions are:
- IDLE to XFER on start.
- XFER to IDLE when the final beat is accepted.
- XFER to XFER when a non-final beat is accepted and the local side is ready.
- XFER to PAUSE when a non-final beat is accepted and the local side is not ready.
- PAUSE to XFER when both the bus and the local side are ready.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, and whenever no burst is active, `htrans` is IDLE (2'b00) and `done` is low.
- R2: A start accepted in IDLE loads `haddr` with the start address and presents NONSEQ (2'b10) in the next cycle. Later beats are SEQ (2'b11). `hsize` and `hwrite` keep the start values for the whole burst.
- R3: Burst codes: 000 single (1 beat), 001 open incrementing, 010/100/110 wrapping of 4/8/16 beats, 011/101/111 incrementing of 4/8/16 beats. On an incrementing burst, each accepted beat advances `haddr` by 2^size bytes.
- R4: On a wrapping burst of N beats, only address bits [size+log2(N)-1 : size] advance, and they wrap modulo N. The bits above stay fixed. For example, a 4-byte size from 0x48 gives 0x48, 0x4C, 0x40, 0x44.
- R5: On an incrementing burst, a beat whose address lies in a different 1 KB region than the beat before it is presented as NONSEQ. From then on `hburst` reads 001.
- R6: While `bus_ready` is low and a beat or BUSY is presented, all outputs hold. A beat counts only on a cycle with `bus_ready` high and `htrans` NONSEQ or SEQ.
- R7: If `local_rdy` is low when a non-final beat is accepted, the next cycle presents BUSY (2'b01) with the next beat's address. BUSY lasts until both readies are high, and it is never followed directly by IDLE.
- R8: An open incrementing burst ends with the beat accepted while `stop_incr` is high.
- R9: `done` is high for exactly the one cycle after the final beat is accepted, and `htrans` is IDLE in that cycle.
- R10: A start asserted while a burst is active is ignored. Its address and parameters do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a burst (taken only in IDLE) |
| start_addr | input | AW | First beat address, aligned to the size |
| size_in | input | 3 | Transfer size code, bytes = 2^size |
| burst_in | input | 3 | Burst code |
| write_in | input | 1 | Direction, 1 = write |
| stop_incr | input | 1 | Ends an open incrementing burst at the accepted beat |
| local_rdy | input | 1 | Local side can take the next beat |
| bus_ready | input | 1 | Bus ready; low stalls the address phase |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst code on the bus |
| hsize | output | 3 | Size on the bus |
| hwrite | output | 1 | Direction on the bus |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench targets the following corner cases:
- **Wrap point for each size and length.** A sequencer that masks only by beat count, and ignores the size, would leave the wrap window at the wrong place.
- **1 KB crossing inside both fixed and open incrementing bursts.** A design that misses it keeps driving SEQ across the boundary. A design that misses the code change leaves `hburst` as a fixed length on the restarted part.
- **Stalls landing on BUSY cycles and on the final beat.** A design that counts a stalled or BUSY cycle as a beat ends the burst early or drifts the address.
- **Start pulses with junk parameters mid-burst.** These catch a design that reloads on any start.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BEAT_W = 5;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_PAUSE
    } seq_state_t;

    localparam logic [2:0] BC_SINGLE = 3'b000;
    localparam logic [2:0] BC_OPEN   = 3'b001;

    // Beat count of a burst code; zero means open-ended.
    function automatic logic [BEAT_W-1:0] burst_beats(input logic [2:0] code);
        logic [BEAT_W-1:0] n;
        unique case (code[2:1])
            2'b00:   n = code[0] ? BEAT_W'(0) : BEAT_W'(1);
            2'b01:   n = BEAT_W'(4);
            2'b10:   n = BEAT_W'(8);
            default: n = BEAT_W'(16);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bseq_addr_step.sv
module bseq_addr_step #(
    parameter int AW       = 32,
    parameter int BOUND_LG = 10
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    size,
    input  logic [2:0]    burst,
    output logic [AW-1:0] nxt_addr,
    output logic          crosses
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic          is_wrap;
    logic [3:0]    span_lg;
    logic [AW-1:0] step;
    logic [AW-1:0] wmask;
    logic [AW-1:0] lin;

    always_comb begin
        is_wrap  = (burst[2:1] != 2'b00) && !burst[0];
        span_lg  = {1'b0, size} + {2'b00, burst[2:1]} + 4'd1;
        step     = ONE << size;
        wmask    = (ONE << span_lg) - ONE;
        lin      = cur_addr + step;
        nxt_addr = is_wrap ? ((cur_addr & ~wmask) | (lin & wmask)) : lin;
        crosses  = !is_wrap && (nxt_addr[AW-1:BOUND_LG] != cur_addr[AW-1:BOUND_LG]);
    end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [CW-1:0] len,
    output logic          last_hit
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clear)   cnt <= '0;
        else if (advance) cnt <= cnt + CW'(1);
    end

    assign last_hit = (len != '0) && ((cnt + CW'(1)) == len);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int BOUND_LG = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [2:0]    size_in,
    input  logic [2:0]    burst_in,
    input  logic          write_in,
    input  logic          stop_incr,
    input  logic          local_rdy,
    input  logic          bus_ready,
    output logic [AW-1:0] haddr,
    output logic [1:0]    htrans,
    output logic [2:0]    hburst,
    output logic [2:0]    hsize,
    output logic          hwrite,
    output logic          done
);
    seq_state_t        st, st_nxt;
    logic [BEAT_W-1:0] len;
    logic              pend_ns;
    logic [AW-1:0]     nxt_addr;
    logic              crosses;
    logic              last_hit;
    logic              take;
    logic              acc;
    logic              fin;

    assign take = (st == ST_IDLE) && start;
    assign acc  = (st == ST_XFER) && bus_ready;
    assign fin  = acc && ((len == '0) ? stop_incr : last_hit);

    bseq_addr_step #(.AW(AW), .BOUND_LG(BOUND_LG)) u_step (
        .cur_addr (haddr),
        .size     (hsize),
        .burst    (hburst),
        .nxt_addr (nxt_addr),
        .crosses  (crosses)
    );

    bseq_beat_ctr #(.CW(BEAT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take),
        .advance  (acc),
        .len      (len),
        .last_hit (last_hit)
    );

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (start) st_nxt = ST_XFER;
            ST_XFER:  if (acc) st_nxt = fin ? ST_IDLE : (local_rdy ? ST_XFER : ST_PAUSE);
            ST_PAUSE: if (bus_ready && local_rdy) st_nxt = ST_XFER;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            haddr   <= '0;
            htrans  <= TR_IDLE;
            hburst  <= BC_SINGLE;
            hsize   <= '0;
            hwrite  <= 1'b0;
            done    <= 1'b0;
            len     <= '0;
            pend_ns <= 1'b0;
        end else begin
            done <= fin;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        haddr  <= start_addr;
                        htrans <= TR_NONSEQ;
                        hburst <= burst_in;
                        hsize  <= size_in;
                        hwrite <= write_in;
                        len    <= burst_beats(burst_in);
                    end
                end
                ST_XFER: begin
                    if (fin) begin
                        htrans <= TR_IDLE;
                    end else if (acc) begin
                        haddr <= nxt_addr;
                        if (local_rdy) begin
                            htrans <= crosses ? TR_NONSEQ : TR_SEQ;
                            if (crosses) hburst <= BC_OPEN;
                        end else begin
                            htrans  <= TR_BUSY;
                            pend_ns <= crosses;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (bus_ready && local_rdy) begin
                        htrans <= pend_ns ? TR_NONSEQ : TR_SEQ;
                        if (pend_ns) hburst <= BC_OPEN;
                    end
                end
                default: htrans <= TR_IDLE;
            endcase
        end
    end

    // R6: a presented beat or BUSY stalled by the bus keeps every output
    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != TR_IDLE && !bus_ready) |=>
            ($stable(haddr) && $stable(htrans) && $stable(hburst) && $stable(hsize)));

    // R2: SEQ only ever follows an active transfer type
    a_r2_seq_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ) |-> ($past(htrans) != TR_IDLE));

    // R9: the completion pulse lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: BUSY is never the closing transfer of a burst
    a_r7_busy_not_last: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_BUSY) |=> (htrans != TR_IDLE));

    // R5: a SEQ beat stays in the 1 KB region of the cycle before
    a_r5_seq_same_region: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ) |-> (haddr[AW-1:BOUND_LG] == $past(haddr[AW-1:BOUND_LG])));

    // R9: the cycle of the pulse shows IDLE
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (htrans == TR_IDLE));

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [2:0]  size_in = '0;
    logic [2:0]  burst_in = '0;
    logic        write_in = 1'b0;
    logic        stop_incr = 1'b0;
    logic        local_rdy = 1'b1;
    logic        bus_ready = 1'b1;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic [2:0]  hburst;
    logic [2:0]  hsize;
    logic        hwrite;
    logic        done;

    always #5 clk = ~clk;

    burst_addr_seq i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .size_in(size_in), .burst_in(burst_in), .write_in(write_in),
        .stop_incr(stop_incr), .local_rdy(local_rdy), .bus_ready(bus_ready),
        .haddr(haddr), .htrans(htrans), .hburst(hburst), .hsize(hsize),
        .hwrite(hwrite), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int mode  = 0;
    int stop_at = 0;
    bit go = 0;
    logic [31:0] g_addr;
    logic [2:0]  g_size, g_burst;
    logic        g_wr;

    // reference state
    int          m_st = 0;
    int          m_k = 0;
    int          m_len = 0;
    bit          m_pend = 0;
    bit          m_done = 0;
    logic [1:0]  m_tr = 2'b00;
    logic [31:0] m_addr = '0;
    logic [2:0]  m_hb = '0;
    logic [31:0] m_start = '0;
    logic [2:0]  m_size = '0;
    logic [2:0]  m_burst = '0;
    logic        m_wr = 1'b0;
    string       m_tag = "R1";

    function automatic int beats_of(logic [2:0] b);
        if (b == 3'b000) return 1;
        if (b == 3'b001) return 0;
        return 2 << b[2:1];
    endfunction

    function automatic bit wrap_of(logic [2:0] b);
        return (b[2:1] != 2'b00) && !b[0];
    endfunction

    function automatic logic [31:0] beat_addr(int k);
        logic [31:0] step, lin, mask;
        step = 32'd1 << m_size;
        lin  = m_start + step * k;
        if (wrap_of(m_burst)) begin
            mask = (32'(beats_of(m_burst)) << m_size) - 32'd1;
            return (m_start & ~mask) | (lin & mask);
        end
        return lin;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_k = 0; m_tr = 2'b00; m_addr = '0; m_hb = '0;
            m_size = '0; m_wr = 1'b0; m_done = 0; m_tag = "R1";
        end else begin
            m_done = 0;
            case (m_st)
                0: begin
                    m_tag = "R1";
                    if (start) begin
                        m_start = start_addr; m_size = size_in; m_burst = burst_in;
                        m_wr = write_in; m_len = beats_of(burst_in); m_k = 0;
                        m_addr = beat_addr(0); m_tr = 2'b10; m_hb = burst_in;
                        m_st = 1; m_tag = "R2";
                    end
                end
                1: begin
                    m_tag = start ? "R10" : "R6";
                    if (bus_ready) begin
                        bit last, cr;
                        m_k++;
                        last = (m_len == 0) ? stop_incr : (m_k == m_len);
                        if (last) begin
                            m_st = 0; m_tr = 2'b00; m_done = 1;
                            m_tag = (m_len == 0) ? "R8" : "R9";
                        end else begin
                            m_addr = beat_addr(m_k);
                            cr = !wrap_of(m_burst) &&
                                 (beat_addr(m_k) >> 10) != (beat_addr(m_k - 1) >> 10);
                            if (local_rdy) begin
                                m_tr = cr ? 2'b10 : 2'b11;
                                if (cr) m_hb = 3'b001;
                                m_tag = cr ? "R5" : (wrap_of(m_burst) ? "R4" : "R3");
                            end else begin
                                m_tr = 2'b01; m_pend = cr; m_st = 2; m_tag = "R7";
                            end
                        end
                    end
                end
                default: begin
                    m_tag = "R6";
                    if (bus_ready && local_rdy) begin
                        m_tr = m_pend ? 2'b10 : 2'b11;
                        if (m_pend) m_hb = 3'b001;
                        m_st = 1; m_tag = m_pend ? "R5" : "R7";
                    end
                end
            endcase
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h cycle=%0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(m_tag, "htrans", 32'(htrans), 32'(m_tr));
        chk(m_tag, "haddr", haddr, m_addr);
        chk(m_tag, "hburst", 32'(hburst), 32'(m_hb));
        chk("R2", "hsize", 32'(hsize), 32'(m_size));
        chk("R2", "hwrite", 32'(hwrite), 32'(m_wr));
        chk(m_done ? "R9" : "R1", "done", 32'(done), 32'(m_done));
        cyc++;
        unique case (mode)
            0: begin bus_ready = 1'b1; local_rdy = 1'b1; end
            1: begin bus_ready = (cyc % 3) != 0; local_rdy = 1'b1; end
            2: begin bus_ready = (cyc % 5) != 2; local_rdy = (cyc % 4) != 1; end
            default: begin bus_ready = 1'b1; local_rdy = (cyc % 3) == 0; end
        endcase
        stop_incr = (m_k == stop_at - 1);
        if (go) begin
            start = 1'b1; start_addr = g_addr; size_in = g_size;
            burst_in = g_burst; write_in = g_wr;
        end else if (mode == 2 && m_st != 0) begin
            // R10: junk start pulses while a burst is active
            start = cyc[1]; start_addr = 32'hFFFF_FFF0; size_in = 3'd0;
            burst_in = 3'b110; write_in = ~g_wr;
        end else begin
            start = 1'b0;
        end
    endtask

    task automatic run(logic [31:0] a, logic [2:0] s, logic [2:0] b, int sa);
        g_addr = a; g_size = s; g_burst = b; g_wr = s[0] ^ b[0]; stop_at = sa;
        go = 1;
        step();
        go = 0;
        for (int i = 0; i < 400; i++) begin
            step();
            if (m_st == 0) break;
        end
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] addrs [4];
        addrs[0] = 32'h48; addrs[1] = 32'h3F4; addrs[2] = 32'h7E0; addrs[3] = 32'h1FC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset htrans", 32'(htrans), 32'h0);
        chk("R1", "reset done", 32'(done), 32'h0);
        rst_n = 1'b1;
        for (int md = 0; md < 4; md++) begin
            mode = md;
            for (int b = 0; b < 8; b++) begin
                for (int s = 0; s < 3; s++) begin
                    for (int ai = 0; ai < 4; ai++) begin
                        // R8: open bursts stop after a chosen beat count
                        run(addrs[ai], 3'(s), 3'(b), 3 + 2 * ai + s);
                    end
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule